// File: doc/BRIEF.md
# Programmable Output Code Command Decoder

This block sits behind a two-wire bus slave that has already matched the device address. It turns the data bytes of a write transaction into one of three commands: a direct write of the 10-bit output code, a write to a small bank of write-once memory slots, or an acquire that reloads the output code from that memory. It holds the output code that drives the converter. It also models four write-once slots, together with a thermometer-coded record of how many of them have been used.

The bus front end passes in each received data byte as a one-cycle strobe. It also passes in START and STOP events and a general-call reset pulse. The decoder answers each byte with an acknowledge flag one cycle later. For read transactions it always presents two response bytes: the usage status with the upper code bits, and the lower code bits. The synchronous active-low reset initialises the whole model, which clears every slot and sets the code to midscale. The general-call reset keeps the slots and reloads the code from them.

Top module: `vcode_cmd_decoder`

## Requirements
- R1: Bits 7:5 of the first data byte select the command. 3'b010 is a memory write, 3'b001 is an acquire, and any other value is a direct code write. For the two-byte commands, code bits 9:8 come from bits 1:0 of the first byte and code bits 7:0 come from the second byte.
- R2: A two-byte command changes nothing after its first byte. The output code updates in the second cycle after the second byte is strobed, and it holds its value in every cycle that carries no completed command.
- R3: A START or STOP that arrives before the second byte of a two-byte command abandons it. The output code and the slots are left unchanged.
- R4: An acquire is a single byte whose bits 4:0 are ignored. It loads the most recently written slot into the code, or 10'h000 when no slot is used.
- R5: At most four memory writes succeed. Once all slots are used, a further memory write leaves the slots, the status and the output code unchanged.
- R6: The usage status is a thermometer: 4'b0000, 4'b0001, 4'b0011, 4'b0111 or 4'b1111 for zero to four used slots.
- R7: Asserting rst_n low clears all slots and sets the code to midscale 10'h200. A general-call reset pulse keeps the slots, loads the most recent slot (or 10'h200 when none is used) and drops any partial command.
- R8: A successful memory write also sets the output code to the written value.
- R9: rd_hi reads {status[3:0], 2'b00, code[9:8]} and rd_lo reads code[7:0].
- R10: byte_ack is high in the cycle after each data byte that belongs to a command, including both bytes of a memory write once the slots are exhausted. Bytes received after a command is complete are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low model initialisation |
| gc_reset | input | 1 | General-call reset pulse |
| start_evt | input | 1 | START or repeated START seen on the bus |
| stop_evt | input | 1 | STOP seen on the bus |
| byte_valid | input | 1 | Strobe for one received write data byte |
| byte_data | input | 8 | Received data byte |
| byte_ack | output | 1 | Acknowledge for the byte strobed one cycle earlier |
| dac_code | output | 10 | Current output code |
| rd_hi | output | 8 | First read byte: status, zeros, code bits 9:8 |
| rd_lo | output | 8 | Second read byte: code bits 7:0 |

## Verification
The embedded properties check the following on every cycle. The code holds whenever no command completes. An abort event is never followed by a commit. A full slot bank never changes. Each successful memory write extends the thermometer by exactly one bit, and that write also lands in the code. Acquire-on-empty and general-call-on-empty load their defaults. Only the directed scenarios show the rest: that the selector bit patterns reach the right command, the byte order and field positions, the choice of the most recent of several slots, the read-byte layout, and the acknowledge pattern across complete, aborted and over-long frames.

// File: rtl/vcd_pkg.sv
// Shared constants and types for the output-code command decoder.
// Assumes a 10-bit code and four write-once slots; the read layout depends on both.
package vcd_pkg;
    localparam int unsigned CODE_W = 10;
    localparam int unsigned NSLOT  = 4;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned HI_W   = CODE_W - BYTE_W;
    localparam int unsigned PAD_W  = BYTE_W - NSLOT - HI_W;

    localparam logic [2:0] SEL_MEM = 3'b010;
    localparam logic [2:0] SEL_ACQ = 3'b001;

    localparam logic [CODE_W-1:0] CODE_MID  = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] CODE_ZERO = '0;

    typedef enum logic [1:0] {
        FR_FIRST  = 2'd0,
        FR_SECOND = 2'd1,
        FR_DONE   = 2'd2
    } frame_state_t;
endpackage

// File: rtl/vcd_frame.sv
// Frame parser. It turns strobed data bytes into one-cycle command pulses.
// Assumes byte_valid pulses once per byte. Any bus event or general-call reset
// returns it to the first-byte state, and that event outranks a byte in the same cycle.
module vcd_frame
    import vcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gc_reset,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              byte_ack,
    output logic              dac_we,
    output logic              mem_we,
    output logic              acq_req,
    output logic [CODE_W-1:0] wr_value
);
    frame_state_t    state_q;
    logic            is_mem_q;
    logic [HI_W-1:0] hi_q;
    logic            abort;
    logic [2:0]      sel;

    assign abort = gc_reset | start_evt | stop_evt;
    assign sel   = byte_data[BYTE_W-1 -: 3];

    // Walk through the bytes of one frame and emit the command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= FR_FIRST;
            is_mem_q <= 1'b0;
            hi_q     <= '0;
            byte_ack <= 1'b0;
            dac_we   <= 1'b0;
            mem_we   <= 1'b0;
            acq_req  <= 1'b0;
            wr_value <= '0;
        end else begin
            byte_ack <= 1'b0;
            dac_we   <= 1'b0;
            mem_we   <= 1'b0;
            acq_req  <= 1'b0;
            if (abort) begin
                state_q <= FR_FIRST;
            end else if (byte_valid) begin
                case (state_q)
                    FR_FIRST: begin
                        byte_ack <= 1'b1;
                        if (sel == SEL_ACQ) begin
                            acq_req <= 1'b1;
                            state_q <= FR_DONE;
                        end else begin
                            is_mem_q <= (sel == SEL_MEM);
                            hi_q     <= byte_data[HI_W-1:0];
                            state_q  <= FR_SECOND;
                        end
                    end
                    FR_SECOND: begin
                        byte_ack <= 1'b1;
                        wr_value <= {hi_q, byte_data};
                        mem_we   <= is_mem_q;
                        dac_we   <= !is_mem_q;
                        state_q  <= FR_DONE;
                    end
                    default: state_q <= FR_DONE;
                endcase
            end
        end
    end

    // R3: an abandoned frame never produces a command in the next cycle
    p_abort_no_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !(dac_we || mem_we || acq_req));

    // R10: bytes after a complete command are not acknowledged
    p_done_no_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_DONE && byte_valid && !abort) |=> !byte_ack);
endmodule

// File: rtl/vcd_slots.sv
// Model of the write-once slot bank. Each successful write fills the next free
// slot and extends the thermometer usage record by one bit. Writes to a
// full bank are dropped. Only rst_n (model initialisation) clears the bank.
module vcd_slots
    import vcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_we,
    input  logic [CODE_W-1:0] wr_value,
    output logic [NSLOT-1:0]  used,
    output logic [CODE_W-1:0] latest,
    output logic              any_used,
    output logic              prog_ok
);
    logic [NSLOT-1:0][CODE_W-1:0] slot_q;

    assign prog_ok  = mem_we && !used[NSLOT-1];
    assign any_used = used[0];

    // Fill the next free slot and extend the usage thermometer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used   <= '0;
            slot_q <= '0;
        end else if (prog_ok) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (!used[i] && (i == 0 || used[(i == 0) ? 0 : i - 1]))
                    slot_q[i] <= wr_value;
            end
            used <= {used[NSLOT-2:0], 1'b1};
        end
    end

    // Select the highest used slot as the most recent value.
    always_comb begin
        latest = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (used[i]) latest = slot_q[i];
        end
    end

    // R5: a full bank never changes
    p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        used[NSLOT-1] |=> ($stable(used) && $stable(slot_q)));

    // R6: each successful write adds exactly one thermometer bit
    p_grow_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ok |=> (used == {$past(used[NSLOT-2:0]), 1'b1}));

    // R6: status is always a thermometer code
    p_thermo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((used & (used + 1'b1)) == '0));
endmodule

// File: rtl/vcd_code.sv
// Output code register. It reacts to model initialisation, general-call reset,
// direct writes, successful memory writes and acquires, in that priority.
// Assumes the command pulses arrive from the frame parser one at a time.
module vcd_code
    import vcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gc_reset,
    input  logic              dac_we,
    input  logic              prog_ok,
    input  logic              acq_req,
    input  logic [CODE_W-1:0] wr_value,
    input  logic [CODE_W-1:0] latest,
    input  logic              any_used,
    output logic [CODE_W-1:0] code
);
    // Choose the next output code from the highest-priority source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= CODE_MID;
        end else if (gc_reset) begin
            if (prog_ok)       code <= wr_value;
            else if (any_used) code <= latest;
            else               code <= CODE_MID;
        end else if (dac_we || prog_ok) begin
            code <= wr_value;
        end else if (acq_req) begin
            code <= any_used ? latest : CODE_ZERO;
        end
    end

    // R2: without a completed command the code holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!gc_reset && !dac_we && !prog_ok && !acq_req) |=> $stable(code));

    // R4: acquire with an empty bank gives zero
    p_acq_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_req && !gc_reset && !any_used) |=> (code == CODE_ZERO));

    // R8: a successful memory write lands in the code
    p_prog_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ok |=> (code == $past(wr_value)));

    // R7: general-call reset with an empty bank gives midscale
    p_gc_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gc_reset && !any_used && !prog_ok) |=> (code == CODE_MID));
endmodule

// File: rtl/vcode_cmd_decoder.sv
// Top of the output-code command decoder: frame parser, slot bank and code
// register, plus the two read-response bytes. Assumes a bus front end that
// delivers write data bytes and bus events as single-cycle strobes.
module vcode_cmd_decoder
    import vcd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        gc_reset,
    input  logic        start_evt,
    input  logic        stop_evt,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    output logic        byte_ack,
    output logic [9:0]  dac_code,
    output logic [7:0]  rd_hi,
    output logic [7:0]  rd_lo
);
    logic              dac_we, mem_we, acq_req, prog_ok, any_used;
    logic [CODE_W-1:0] wr_value, latest, code;
    logic [NSLOT-1:0]  used;

    vcd_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .gc_reset  (gc_reset),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .byte_valid(byte_valid),
        .byte_data (byte_data),
        .byte_ack  (byte_ack),
        .dac_we    (dac_we),
        .mem_we    (mem_we),
        .acq_req   (acq_req),
        .wr_value  (wr_value)
    );

    vcd_slots u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .mem_we  (mem_we),
        .wr_value(wr_value),
        .used    (used),
        .latest  (latest),
        .any_used(any_used),
        .prog_ok (prog_ok)
    );

    vcd_code u_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .gc_reset(gc_reset),
        .dac_we  (dac_we),
        .prog_ok (prog_ok),
        .acq_req (acq_req),
        .wr_value(wr_value),
        .latest  (latest),
        .any_used(any_used),
        .code    (code)
    );

    assign dac_code = code;
    assign rd_hi    = {used, {PAD_W{1'b0}}, code[CODE_W-1 -: HI_W]};
    assign rd_lo    = code[BYTE_W-1:0];
endmodule

// File: tb/tb_vcode_cmd_decoder.sv
`timescale 1ns/1ps
module tb_vcode_cmd_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gc_reset = 1'b0;
    logic       start_evt = 1'b0;
    logic       stop_evt = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       byte_ack;
    logic [9:0] dac_code;
    logic [7:0] rd_hi, rd_lo;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    vcode_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ack(byte_ack), .dac_code(dac_code),
        .rd_hi(rd_hi), .rd_lo(rd_lo)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic ev_start();
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
    endtask

    task automatic ev_stop();
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
    endtask

    task automatic ev_gc();
        @(negedge clk); gc_reset = 1'b1;
        @(negedge clk); gc_reset = 1'b0;
    endtask

    task automatic two_byte(input logic [7:0] b1, input logic [7:0] b2, input string tag);
        ev_start();
        send_byte(b1);
        chk({tag, " ack1 R10"}, 16'(byte_ack), 16'h1);
        send_byte(b2);
        chk({tag, " ack2 R10"}, 16'(byte_ack), 16'h1);
        settle();
        ev_stop();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R7 init code", 16'(dac_code), 16'h200);
        chk("R6 init status / R9 rd_hi", 16'(rd_hi), 16'h02);
        chk("R9 rd_lo", 16'(rd_lo), 16'h00);
    endtask

    task automatic t_direct_write();
        ev_start();
        send_byte(8'h03);
        chk("R10 ack first", 16'(byte_ack), 16'h1);
        settle();
        chk("R2 no change after first byte", 16'(dac_code), 16'h200);
        send_byte(8'h55);
        chk("R10 ack second", 16'(byte_ack), 16'h1);
        settle();
        chk("R1 direct write", 16'(dac_code), 16'h355);
        chk("R9 rd_hi", 16'(rd_hi), 16'h03);
        chk("R9 rd_lo", 16'(rd_lo), 16'h55);
        ev_stop();
        two_byte(8'hE1, 8'h0A, "R1 sel111");
        chk("R1 other selector is direct write", 16'(dac_code), 16'h10A);
    endtask

    task automatic t_abort();
        ev_start();
        send_byte(8'h02);
        ev_stop();
        settle();
        chk("R3 stop aborts direct write", 16'(dac_code), 16'h10A);
        ev_start();
        send_byte(8'h41);
        ev_start();
        send_byte(8'h77);
        settle();
        chk("R3 start aborts memory write code", 16'(dac_code), 16'h10A);
        chk("R3 start aborts memory write status", 16'(rd_hi[7:4]), 16'h0);
        ev_stop();
    endtask

    task automatic t_acquire_empty();
        ev_start();
        send_byte(8'h3F);
        chk("R10 acquire ack", 16'(byte_ack), 16'h1);
        settle();
        chk("R4 acquire empty gives zero", 16'(dac_code), 16'h000);
        send_byte(8'h12);
        chk("R10 extra byte not acked", 16'(byte_ack), 16'h0);
        settle();
        chk("R10 extra byte no effect", 16'(dac_code), 16'h000);
        ev_stop();
    endtask

    task automatic t_mem_writes();
        two_byte(8'h41, 8'h11, "mem1");
        chk("R8 mem1 code", 16'(dac_code), 16'h111);
        chk("R6 mem1 rd_hi", 16'(rd_hi), 16'h11);
        two_byte(8'h42, 8'h22, "mem2");
        chk("R6 mem2 rd_hi", 16'(rd_hi), 16'h32);
        two_byte(8'h43, 8'h33, "mem3");
        chk("R6 mem3 rd_hi", 16'(rd_hi), 16'h73);
        two_byte(8'h40, 8'h44, "mem4");
        chk("R8 mem4 code", 16'(dac_code), 16'h044);
        chk("R6 mem4 rd_hi", 16'(rd_hi), 16'hF0);
        two_byte(8'h43, 8'hFF, "mem5 R5");
        chk("R5 fifth write ignored code", 16'(dac_code), 16'h044);
        chk("R5 fifth write ignored status", 16'(rd_hi), 16'hF0);
    endtask

    task automatic t_acquire_latest();
        two_byte(8'h01, 8'h00, "direct");
        chk("R1 direct write", 16'(dac_code), 16'h100);
        ev_start();
        send_byte(8'h20);
        settle();
        chk("R4 acquire loads latest slot", 16'(dac_code), 16'h044);
        ev_stop();
    endtask

    task automatic t_gc();
        two_byte(8'h03, 8'hFF, "direct");
        chk("R1 direct full", 16'(dac_code), 16'h3FF);
        ev_gc();
        settle();
        chk("R7 gc loads latest", 16'(dac_code), 16'h044);
        chk("R7 gc keeps slots", 16'(rd_hi[7:4]), 16'hF);
        ev_start();
        send_byte(8'h02);
        ev_gc();
        send_byte(8'h99);
        chk("R7 byte after gc starts new frame", 16'(byte_ack), 16'h1);
        settle();
        chk("R7 gc drops partial frame", 16'(dac_code), 16'h044);
        ev_stop();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R7 init clears slots", 16'(rd_hi), 16'h02);
        ev_gc();
        settle();
        chk("R7 gc on empty gives midscale", 16'(dac_code), 16'h200);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_direct_write();
        t_abort();
        t_acquire_empty();
        t_mem_writes();
        t_acquire_latest();
        t_gc();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule